// File: doc/BRIEF.md
# Modem Handshake Control and Status

This block handles the modem handshake lines of a serial port. A processor writes a small control register whose low four bits drive four active-low handshake outputs (data-terminal-ready, request-to-send and two general-purpose outputs). A fifth bit selects a loopback mode. In loopback the handshake pins are disconnected and held inactive, and the control bits are routed internally back into the status inputs.

Four active-low modem inputs are brought into the clock domain by a flop synchronizer: clear-to-send, data-set-ready, ring indicator and carrier detect. The processor reads a status byte. Its upper nibble shows the true-sense line levels. Its lower nibble holds sticky change flags, and a read of the status register clears those flags. The ring flag records only the end of a ring, when the true-sense ring level falls. While any flag is set and the interrupt enable input is high, a modem interrupt request is raised.

Top module: `modem_ctl_top`

## Requirements
- R1: After reset all four handshake outputs are high. The control register reads 0x00. With all inputs high the status register reads 0x00, and the interrupt request is low.
- R2: A control write (regSel=0) drives the outputs as follows while bit 4 is 0: bit 0 to dtrN, bit 1 to rtsN, bit 2 to out1N and bit 3 to out2N. A 1 drives the pin low and a 0 drives it high. A control read returns the five written bits in bits 4..0, with 0 in bits 7..5.
- R3: While control bit 4 (loopback) is 1, dtrN, rtsN, out1N and out2N are all high, whatever bits 3..0 hold.
- R4: Outside loopback the status bits show the complement of the inputs after a two-flop synchronizer: bit 7 is ~dcdN, bit 6 is ~riN, bit 5 is ~dsrN and bit 4 is ~ctsN.
- R5: Status bit 0 sets on any change of CTS, bit 1 on any change of DSR and bit 3 on any change of DCD. Each stays set until cleared.
- R6: Status bit 2 sets only when the true-sense ring level goes from 1 to 0 (riN rises). A falling riN leaves it clear.
- R7: A status read (rdEn with regSel=1) clears bits 3..0 after the read. A control register read leaves them untouched.
- R8: In loopback the status levels come from the control bits, and the external inputs are ignored. Control bit 0 feeds bit 5, bit 1 feeds bit 4, bit 2 feeds bit 6 and bit 3 feeds bit 7.
- R9: modemIrq is high exactly while irqEnable is high and any of status bits 3..0 is set.
- R10: A write with regSel=1 has no effect: the outputs and the control readback do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 1 | 0 selects the control register, 1 selects the status register |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe; a status read clears the flags |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data (combinational) |
| irqEnable | input | 1 | Modem interrupt enable |
| ctsN | input | 1 | Clear-to-send, active low |
| dsrN | input | 1 | Data-set-ready, active low |
| riN | input | 1 | Ring indicator, active low |
| dcdN | input | 1 | Carrier detect, active low |
| dtrN | output | 1 | Data-terminal-ready, active low |
| rtsN | output | 1 | Request-to-send, active low |
| out1N | output | 1 | General output 1, active low |
| out2N | output | 1 | General output 2, active low |
| modemIrq | output | 1 | Modem status interrupt request |

## Verification
A vector walk drives each control bit alone, each input alone, and mixed patterns. The mixed patterns separate a swapped pin mapping from a correct one. Loopback rows apply each control bit on its own while the external inputs are held at the opposite level, which exposes a wrong internal cross-routing or leakage from the pins. Directed sequences toggle each input in both directions. These show whether the change flags are sticky, whether the ring flag reacts to the correct edge only, and whether a read of the wrong register clears the flags. Toggling the interrupt enable around a pending flag separates gating from latching.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int DATA_W  = 8;
  localparam int CTRL_W  = 5;
  localparam int LINES   = 4;
  // line indices, shared by the flag and level nibbles
  localparam int L_CTS = 0;
  localparam int L_DSR = 1;
  localparam int L_RI  = 2;
  localparam int L_DCD = 3;
  localparam int C_LOOP = 4;

  typedef struct packed {
    logic             clearFlags;
    logic             loopMode;
    logic [LINES-1:0] loopLines;  // true-sense levels in line order
  } mdmStrobe_t;
endpackage

// File: rtl/mdm_ctrl.sv
module mdm_ctrl
  import mdm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] statusByte,
  output logic [DATA_W-1:0] rdData,
  output mdmStrobe_t        strobe,
  output logic              dtrN,
  output logic              rtsN,
  output logic              out1N,
  output logic              out2N
);
  logic [CTRL_W-1:0] ctrlQ;
  logic              loopOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               ctrlQ <= '0;
    else if (wrEn && !regSel) ctrlQ <= wrData[CTRL_W-1:0];
  end

  assign loopOn = ctrlQ[C_LOOP];

  always_comb begin
    dtrN  = loopOn | ~ctrlQ[0];
    rtsN  = loopOn | ~ctrlQ[1];
    out1N = loopOn | ~ctrlQ[2];
    out2N = loopOn | ~ctrlQ[3];
  end

  always_comb begin
    strobe.clearFlags       = rdEn && regSel;
    strobe.loopMode         = loopOn;
    strobe.loopLines[L_CTS] = ctrlQ[1];
    strobe.loopLines[L_DSR] = ctrlQ[0];
    strobe.loopLines[L_RI]  = ctrlQ[2];
    strobe.loopLines[L_DCD] = ctrlQ[3];
  end

  always_comb begin
    if (regSel) rdData = statusByte;
    else        rdData = {{(DATA_W-CTRL_W){1'b0}}, ctrlQ};
  end

  p_write_map_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !regSel && !wrData[C_LOOP]) |=>
      (dtrN == !$past(wrData[0]) && rtsN == !$past(wrData[1]) &&
       out1N == !$past(wrData[2]) && out2N == !$past(wrData[3])));

  p_loop_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !regSel && wrData[C_LOOP]) |=> ({dtrN, rtsN, out1N, out2N} == 4'hF));

  p_status_ro_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel) |=> $stable({dtrN, rtsN, out1N, out2N}));
endmodule

// File: rtl/mdm_status.sv
module mdm_status
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINES-1:0]  linesN,
  input  mdmStrobe_t        strobe,
  input  logic              irqEnable,
  output logic [DATA_W-1:0] statusByte,
  output logic              modemIrq
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][LINES-1:0] syncQ;
  logic [LINES-1:0] srcN, prevN, setVec, flagQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= '1;
    else       syncQ[0] <= linesN;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[s] <= '1;
      else       syncQ[s] <= syncQ[s-1];
    end
  end

  assign srcN = strobe.loopMode ? ~strobe.loopLines : syncQ[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevN <= '1;
    else       prevN <= srcN;
  end

  for (genvar i = 0; i < LINES; i++) begin : g_edge
    if (i == L_RI) begin : g_trail
      // true-sense level falls: active-low line goes 0 -> 1
      assign setVec[i] = srcN[i] & ~prevN[i];
    end else begin : g_any
      assign setVec[i] = srcN[i] ^ prevN[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= (flagQ & ~{LINES{strobe.clearFlags}}) | setVec;
  end

  assign statusByte = {~srcN, flagQ};
  assign modemIrq   = irqEnable & (|flagQ);

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clearFlags |=> ((flagQ & $past(flagQ)) == $past(flagQ)));

  p_ri_edge_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ[L_RI]) |-> (prevN[L_RI] && !$past(prevN[L_RI])));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clearFlags && setVec == '0) |=> (flagQ == '0));
endmodule

// File: rtl/modem_ctl_top.sv
module modem_ctl_top
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regSel,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  input  logic        irqEnable,
  input  logic        ctsN,
  input  logic        dsrN,
  input  logic        riN,
  input  logic        dcdN,
  output logic        dtrN,
  output logic        rtsN,
  output logic        out1N,
  output logic        out2N,
  output logic        modemIrq
);
  mdmStrobe_t        strobe;
  logic [DATA_W-1:0] statusByte;
  logic [LINES-1:0]  linesN;

  assign linesN = {dcdN, riN, dsrN, ctsN};

  mdm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .statusByte(statusByte), .rdData(rdData),
    .strobe(strobe), .dtrN(dtrN), .rtsN(rtsN), .out1N(out1N), .out2N(out2N)
  );

  mdm_status #(.SYNC_STAGES(SYNC_STAGES)) u_status (
    .clk(clk), .rstN(rstN), .linesN(linesN), .strobe(strobe),
    .irqEnable(irqEnable), .statusByte(statusByte), .modemIrq(modemIrq)
  );
endmodule

// File: tb/modem_ctl_top_bench.sv
module modem_ctl_top_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regSel = 1'b0, wrEn = 1'b0, rdEn = 1'b0, irqEnable = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic ctsN = 1'b1, dsrN = 1'b1, riN = 1'b1, dcdN = 1'b1;
  logic dtrN, rtsN, out1N, out2N, modemIrq;
  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  modem_ctl_top u_modem_ctl_top (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .irqEnable(irqEnable),
    .ctsN(ctsN), .dsrN(dsrN), .riN(riN), .dcdN(dcdN),
    .dtrN(dtrN), .rtsN(rtsN), .out1N(out1N), .out2N(out2N), .modemIrq(modemIrq)
  );

  // {ctrl[7:0], pins {dcdN,riN,dsrN,ctsN}, outs {out2N,out1N,rtsN,dtrN}, status[7:4]}
  localparam logic [19:0] VEC [14] = '{
    20'h00FF0, 20'h01EE1, 20'h02DD2, 20'h04BB4, 20'h08778, 20'h0F00F, 20'h05AA5,
    20'h100F0, 20'h110F2, 20'h120F1, 20'h140F4, 20'h180F8, 20'h1FFFF, 20'h0A55A
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); regSel = sel; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    @(negedge clk); regSel = sel; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  function automatic logic [7:0] outs();
    return {4'h0, out2N, out1N, rtsN, dtrN};
  endfunction

  initial begin
    #(8 * 20000);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    idle(3);
    // R1 reset state
    check("R1 outs", outs(), 8'h0F);
    check("R1 irq", {7'd0, modemIrq}, 8'h00);
    rstN = 1'b1;
    idle(2);
    rd(1'b0, d); check("R1 ctrl", d, 8'h00);
    rd(1'b1, d); check("R1 status", d, 8'h00);

    // vector walk: R2 R3 R4 R8
    foreach (VEC[i]) begin
      wr(1'b0, VEC[i][19:12]);
      {dcdN, riN, dsrN, ctsN} = VEC[i][11:8];
      idle(5);
      check(VEC[i][16] ? "R3 loop outs" : "R2 outs", outs(), {4'h0, VEC[i][7:4]});
      rd(1'b0, d); check("R2 ctrl readback", d, {3'b0, VEC[i][16:12]});
      rd(1'b1, d);
      check(VEC[i][16] ? "R8 loop status" : "R4 status", {d[7:4], 4'h0}, {VEC[i][3:0], 4'h0});
    end

    // quiet start
    wr(1'b0, 8'h00); {dcdN, riN, dsrN, ctsN} = 4'hF; idle(5);
    rd(1'b1, d); rd(1'b1, d);
    check("R7 clear", d, 8'h00);

    // R5 deltas, both directions
    ctsN = 1'b0; idle(5); rd(1'b1, d); check("R5 cts fall", d, 8'h11);
    rd(1'b1, d); check("R7 cleared after read", d, 8'h10);
    ctsN = 1'b1; idle(5); rd(1'b1, d); check("R5 cts rise", d, 8'h01);
    dsrN = 1'b0; idle(5); rd(1'b1, d); check("R5 dsr", d, 8'h22);
    dcdN = 1'b0; idle(5); rd(1'b1, d); check("R5 dcd", d, 8'hA8);
    dsrN = 1'b1; dcdN = 1'b1; idle(5); rd(1'b1, d); check("R5 two lines", d, 8'h0A);

    // R6 ring edge
    riN = 1'b0; idle(5); rd(1'b1, d); check("R6 ring start ignored", d, 8'h40);
    riN = 1'b1; idle(5);
    rd(1'b0, d); check("R7 ctrl read", d, 8'h00);
    rd(1'b1, d); check("R6 ring end + R7 ctrl read kept flag", d, 8'h04);

    // R9 interrupt gating
    ctsN = 1'b0; idle(5);
    check("R9 disabled", {7'd0, modemIrq}, 8'h00);
    irqEnable = 1'b1; #1;
    check("R9 enabled", {7'd0, modemIrq}, 8'h01);
    rd(1'b1, d); idle(1);
    check("R9 cleared", {7'd0, modemIrq}, 8'h00);
    ctsN = 1'b1; idle(5);
    check("R9 new event", {7'd0, modemIrq}, 8'h01);
    irqEnable = 1'b0; #1;
    check("R9 enable off", {7'd0, modemIrq}, 8'h00);
    rd(1'b1, d);

    // R10 status write ignored
    wr(1'b1, 8'h0F); idle(2);
    check("R10 outs", outs(), 8'h0F);
    rd(1'b0, d); check("R10 ctrl", d, 8'h00);

    // R3 loop overrides a full control nibble
    wr(1'b0, 8'h1F); idle(2);
    check("R3 loop full", outs(), 8'h0F);
    wr(1'b0, 8'h0F); idle(2);
    check("R2 after loop", outs(), 8'h00);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule